// File: doc/BRIEF.md
# Display Link High-Speed Clock Stop Controller

This block decides when the high-speed DDR clock of a serial display link may be stopped. It drives one registered stop request, `stopClk`. When the request is 1, the clock is allowed to stop. When it is 0, the clock must keep running. The request reaches the PLL controller and PHY through further pipeline stages, so a consumer must not expect the clock to stop in the same cycle that the request changes.

Software sets the control state through a small register write port. The control state covers:
- an interface enable,
- a choice between automatic and manual operation,
- a manual stop bit,
- an always-on override,
- an enable bit and a video/command mode bit for each of four virtual channels.

Two inputs come from the link logic:
- `hsBusy` reports a high-speed transfer that is running or queued.
- `chanHsNeed` has one bit per channel. A bit reports that the channel's command traffic needs high speed.

In automatic operation the block stops the clock only when no condition still needs it. In manual operation the manual stop bit alone decides. The always-on override can be changed only while the interface is disabled.

Top module: `linkClkStop`

## Requirements
- R1: While the interface enable bit is 0, `stopClk` is 1 regardless of any other input or register. `stopClk` can be 0 only in a cycle that follows a cycle in which the interface enable bit was 1.
- R2: In automatic mode with the interface enabled, `stopClk` is 1 when all of the following hold: the always-on bit is 0, `hsBusy` is 0, no enabled channel is in video mode, and no enabled command-mode channel has its `chanHsNeed` bit set. Automatic mode means auto bit = 1.
- R3: In automatic mode with the interface enabled, `stopClk` is 0 when any one of these holds: the always-on bit is 1, `hsBusy` is 1, an enabled channel is in video mode, or an enabled command-mode channel has its `chanHsNeed` bit set.
- R4: A channel is video-active when its enable bit is 1 and its mode bit is 1. An enabled channel whose mode bit is 0 is in command mode and holds the clock on only through its `chanHsNeed` bit. On a disabled channel, the mode bit and the `chanHsNeed` bit have no effect.
- R5: In manual mode (auto bit = 0) with the interface enabled, `stopClk` equals the manual stop bit.
- R6: The always-on bit is loaded by a write to address 0 only when the stored interface enable bit is 0 before that write. At any other time the always-on field of the write is ignored, and the other fields of the same write still take effect.
- R7: After reset, all control and channel bits are 0 and `stopClk` is 1.
- R8: `stopClk` is registered. A change on `hsBusy` or `chanHsNeed` appears on it after one rising clock edge. A register write appears on it after two rising clock edges.
- R9: The register map is as follows:
  - Address 0 holds: bit 0 interface enable, bit 1 auto, bit 2 manual stop, bit 3 always-on.
  - Address 1 holds channel enables in bits [3:0] (bit i is channel i) and channel mode bits in bits [7:4] (bit 4+i is channel i, 1 = video).
  - A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (2) | Register write address |
| wrData | input | DATA_W (8) | Register write data |
| hsBusy | input | 1 | A high-speed transfer is running or queued |
| chanHsNeed | input | NUM_CH (4) | Per channel: command traffic needs high speed |
| stopClk | output | 1 | Registered request: 1 = the DDR clock may stop |

## Verification
A change on `hsBusy` or `chanHsNeed` is due on `stopClk` one rising edge after it is applied. A register write needs two edges: one to load the register and one to register the output. The bench drives all inputs on the falling edge. It holds a behavioural model that is advanced on the same rising edges, and it compares `stopClk` with the model on every falling edge. Directed checks wait one or two falling edges to match the latency of each stimulus. One check also confirms that `stopClk` still holds its old value one edge after a write.

// File: rtl/linkStopPkg.sv
package linkStopPkg;
  localparam int CTRL_ADDR = 0;
  localparam int CHAN_ADDR = 1;
  localparam int IF_BIT    = 0;
  localparam int AUTO_BIT  = 1;
  localparam int MAN_BIT   = 2;
  localparam int AO_BIT    = 3;

  typedef struct packed {
    logic ctrlWr;        // load enable, auto and manual fields
    logic alwaysOnLoad;  // load the always-on field
    logic chanWr;        // load channel enable and mode fields
  } strobeT;
endpackage

// File: rtl/linkStopCtrl.sv
module linkStopCtrl
  import linkStopPkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              ifEnable,
  output strobeT            stb
);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] ChanAddr = ADDR_W'(CHAN_ADDR);

  logic ctrlHit;

  always_comb begin
    ctrlHit          = wrEn && (wrAddr == CtrlAddr);
    stb.ctrlWr       = ctrlHit;
    stb.alwaysOnLoad = ctrlHit && !ifEnable;   // the override is locked while the link is up
    stb.chanWr       = wrEn && (wrAddr == ChanAddr);
  end
endmodule

// File: rtl/linkStopData.sv
module linkStopData
  import linkStopPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hsBusy,
  input  logic [NUM_CH-1:0] chanHsNeed,
  output logic              ifEnable,
  output logic              stopClk
);
  logic              autoStop;
  logic              manualStop;
  logic              alwaysOn;
  logic [NUM_CH-1:0] chanEn;
  logic [NUM_CH-1:0] chanVid;
  logic [NUM_CH-1:0] videoAct;
  logic [NUM_CH-1:0] cmdHs;
  logic              clkNeeded;
  logic              nextStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifEnable   <= 1'b0;
      autoStop   <= 1'b0;
      manualStop <= 1'b0;
      alwaysOn   <= 1'b0;
      chanEn     <= '0;
      chanVid    <= '0;
    end else begin
      if (stb.ctrlWr) begin
        ifEnable   <= wrData[IF_BIT];
        autoStop   <= wrData[AUTO_BIT];
        manualStop <= wrData[MAN_BIT];
      end
      if (stb.alwaysOnLoad) alwaysOn <= wrData[AO_BIT];
      if (stb.chanWr) begin
        chanEn  <= wrData[NUM_CH-1:0];
        chanVid <= wrData[2*NUM_CH-1:NUM_CH];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    assign videoAct[ch] = chanEn[ch] && chanVid[ch];
    assign cmdHs[ch]    = chanEn[ch] && !chanVid[ch] && chanHsNeed[ch];
  end

  always_comb begin
    clkNeeded = alwaysOn || hsBusy || (|videoAct) || (|cmdHs);
    if (!ifEnable)     nextStop = 1'b1;
    else if (autoStop) nextStop = !clkNeeded;
    else               nextStop = manualStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopClk <= 1'b1;
    else       stopClk <= nextStop;
  end

  AST_IF_OFF_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> stopClk);  // R1
  AST_RUN_NEEDS_IF: assert property (@(posedge clk) disable iff (!rstN)
    !stopClk |-> $past(ifEnable));  // R1
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && autoStop && (alwaysOn || hsBusy)) |=> !stopClk);  // R3
  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && !autoStop) |=> (stopClk == $past(manualStop)));  // R5
  AST_AO_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ifEnable |=> $stable(alwaysOn));  // R6
endmodule

// File: rtl/linkClkStop.sv
module linkClkStop
  import linkStopPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hsBusy,
  input  logic [NUM_CH-1:0] chanHsNeed,
  output logic              stopClk
);
  strobeT stb;
  logic   ifEnable;

  linkStopCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ifEnable (ifEnable),
    .stb      (stb)
  );

  linkStopData #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .hsBusy     (hsBusy),
    .chanHsNeed (chanHsNeed),
    .ifEnable   (ifEnable),
    .stopClk    (stopClk)
  );
endmodule

// File: tb/test_linkClkStop.sv
module test_linkClkStop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       hsBusy = 1'b0;
  logic [3:0] chanHsNeed = '0;
  logic       stopClk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference state
  bit mIf, mAuto, mMan, mAo;
  bit [3:0] mEn, mVid;
  bit expStop;

  always #5 clk = ~clk;

  linkClkStop i_linkClkStop (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsBusy(hsBusy), .chanHsNeed(chanHsNeed), .stopClk(stopClk)
  );

  function automatic bit refStop();
    bit need;
    need = mAo || hsBusy;
    for (int c = 0; c < 4; c++) begin
      if (mEn[c] && mVid[c]) need = 1;
      if (mEn[c] && !mVid[c] && chanHsNeed[c]) need = 1;
    end
    if (!mIf) return 1'b1;
    if (mAuto) return !need;
    return mMan;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIf <= 0; mAuto <= 0; mMan <= 0; mAo <= 0; mEn <= 0; mVid <= 0;
      expStop <= 1;
    end else begin
      expStop <= refStop();
      if (wrEn && wrAddr == 2'd0) begin
        mIf <= wrData[0]; mAuto <= wrData[1]; mMan <= wrData[2];
        if (!mIf) mAo <= wrData[3];
      end
      if (wrEn && wrAddr == 2'd1) begin
        mEn <= wrData[3:0]; mVid <= wrData[7:4];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (stopClk !== expStop) begin
        errors++;
        $display("FAIL %s model compare: stopClk=%0b expected=%0b",
                 !mIf ? "R1" : (mAuto ? "R2/R3" : "R5"), stopClk, expStop);
      end
    end
  end

  task automatic chk(string tag, bit exp);
    checks++;
    if (stopClk !== exp) begin
      errors++;
      $display("FAIL %s: stopClk=%0b expected=%0b", tag, stopClk, exp);
    end
  endtask

  // write launched on a falling edge; returns on the falling edge after the load edge
  task automatic wr(bit [1:0] a, bit [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrAddr = '0; wrData = '0;
  endtask

  function automatic bit [7:0] ctl(bit en, bit au, bit man, bit ao);
    return {4'b0, ao, man, au, en};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected<100000", cycles);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset value", 1);
    rstN = 1;
    @(negedge clk);
    chk("R7 after reset release", 1);

    // R1: inputs asking for the clock while the interface is off
    hsBusy = 1; chanHsNeed = 4'hF;
    @(negedge clk); chk("R1 disabled ignores inputs", 1);
    hsBusy = 0; chanHsNeed = 0;

    // R2 auto mode, everything idle
    wr(2'd0, ctl(1, 1, 0, 0)); @(negedge clk);
    chk("R2 auto idle stops", 1);

    // R3/R8: hsBusy takes effect after one edge
    hsBusy = 1; @(negedge clk); chk("R3 R8 hsBusy holds clock", 0);
    hsBusy = 0; @(negedge clk); chk("R8 hsBusy release", 1);

    // R4: enabled command channel without need does not hold clock
    wr(2'd1, 8'b0000_0100); @(negedge clk);
    chk("R4 command channel idle", 1);
    chanHsNeed = 4'b0100; @(negedge clk); chk("R3 command needs HS", 0);
    chanHsNeed = 4'b0010; @(negedge clk); chk("R4 disabled channel need ignored", 1);
    chanHsNeed = 0;
    wr(2'd1, 8'b0010_0000); @(negedge clk);
    chk("R4 disabled channel video bit ignored", 1);
    wr(2'd1, 8'b0001_0001); @(negedge clk);
    chk("R4 video channel holds clock", 0);
    wr(2'd1, 8'h00); @(negedge clk);

    // R6: always-on write while enabled is ignored
    wr(2'd0, ctl(1, 1, 0, 1)); @(negedge clk);
    chk("R6 always-on locked while enabled", 1);

    // R9: unmapped address has no effect
    wr(2'd2, 8'hFF); @(negedge clk);
    chk("R9 unmapped write ignored", 1);
    wr(2'd3, 8'h00); @(negedge clk);
    chk("R9 unmapped write ignored (enable kept)", 1);
    hsBusy = 1; @(negedge clk); chk("R9 interface still enabled", 0);
    hsBusy = 0; @(negedge clk);

    // R1 then R6: set always-on while disabled, then enable
    wr(2'd0, ctl(0, 1, 0, 1)); @(negedge clk);
    chk("R1 disabled stops", 1);
    wr(2'd0, ctl(1, 1, 0, 1)); @(negedge clk);
    chk("R3 R6 always-on loaded while disabled", 0);

    // R5 manual mode ignores always-on
    wr(2'd0, ctl(1, 0, 1, 0)); @(negedge clk);
    chk("R5 manual stop=1", 1);
    wr(2'd0, ctl(1, 0, 0, 0));
    chk("R8 write not visible after one edge", 1);
    @(negedge clk); chk("R5 manual stop=0", 0);
    hsBusy = 1; chanHsNeed = 4'hF; @(negedge clk);
    chk("R5 manual ignores inputs", 0);
    hsBusy = 0; chanHsNeed = 0;

    // R1 disable forces stop
    wr(2'd0, ctl(0, 0, 0, 0)); @(negedge clk);
    chk("R1 disable forces stop", 1);
    wr(2'd0, ctl(1, 1, 0, 0)); @(negedge clk);
    chk("R2 auto after clearing always-on", 1);

    repeat (3) @(negedge clk);
    finish();
  end
endmodule